// File: doc/BRIEF.md
# Quadrant-Extended Cross-Parity ECC Codec

This block protects a 64-bit data word laid out as an 8x8 bit array, with data bit index = row*8 + column. The encoder is combinational. It produces 20 check bits: a parity bit for each row, a parity bit for each column, and a parity bit for each of the four quadrants. The quadrant parities are what let the decoder locate and repair a two-bit error whose bits sit in diagonally opposite quadrants. Plain row/column parity could only detect such an error.

The decoder takes a received data word and its stored check bits, all sampled on a strobe. It compares freshly computed parities against the stored ones. Every single-bit data error is repaired, and so is every diagonal two-bit error. Any other non-zero mismatch pattern is reported as uncorrectable, and the data is passed through untouched. One clock after the strobe, the decoder presents the result word and a fresh set of check bits computed from that word.

Top module: `xp_ecc_codec`

## Requirements
- R1: `enc_check_o` holds the parities of `enc_data_i`. Bits [7:0] hold the parity of rows 0..7 (bit r covers data bits r*8..r*8+7). Bits [15:8] hold the parity of columns 0..7. Bits [19:16] hold the quadrant parities in the order QA (rows 0-3, cols 0-3), QB (rows 0-3, cols 4-7), QC (rows 4-7, cols 4-7), QD (rows 4-7, cols 0-3).
- R2: The decoder outputs update on the rising edge after a cycle with `dec_valid_i` high. After a cycle with it low, both flags are 0, and `corrected_data` and `check_out` keep their values.
- R3: A single flipped data bit is restored, and `err_corrected` is set.
- R4: Two flipped data bits, one in QA and one in QC, or one in QB and one in QD, are both restored, and `err_corrected` is set.
- R5: Any other two-bit data error sets `err_uncorrectable`, and `corrected_data` equals the received data.
- R6: One or two flipped check bits with clean data set `err_uncorrectable`, and no data bit is changed.
- R7: A contiguous burst of 2 to 7 bits in data index order is never accepted silently. It is either flagged uncorrectable with the data unchanged, or, only for the two-bit burst across bits 31/32, repaired.
- R8: `check_out` always equals the parity set (R1 layout) of `corrected_data`.
- R9: A received word whose check bits match yields no flag and passes the data unchanged.
- R10: A synchronous active-high `rst` clears all decoder outputs to 0.
- R11: `err_corrected` and `err_uncorrectable` are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_data_i | input | 64 | Word to encode |
| enc_check_o | output | 20 | Check bits of `enc_data_i` (combinational) |
| dec_valid_i | input | 1 | Strobe: sample the received word this cycle |
| dec_data_i | input | 64 | Received data |
| dec_check_i | input | 20 | Received check bits |
| corrected_data | output | 64 | Repaired (or passed-through) data, registered |
| check_out | output | 20 | Check bits recomputed from `corrected_data`, registered |
| err_corrected | output | 1 | One or two data bits were repaired |
| err_uncorrectable | output | 1 | Mismatch that could not be repaired |

## Verification
The bench applies diagonal pairs at the extreme corners (bits 0 and 63) and at the mid rows. A decoder that mixes up the half boundaries or the pairing of quadrants would flip the wrong two bits, leaving four bad bits while still claiming success. Same-row, same-quadrant and side-by-side-quadrant pairs are applied too; a loose pattern test would "repair" them and corrupt a third and fourth bit. Check-bit-only errors test that a lone row or column mismatch is not mistaken for a data error. Bursts, including the one crossing the row 3/4 boundary, test that a long burst never decays into a false single or double fix.

// File: rtl/xp_ecc_pkg.sv
package xp_ecc_pkg;
  localparam int XP_SIDE = 8;
  localparam int XP_HALF = XP_SIDE / 2;
  localparam int XP_DW   = XP_SIDE * XP_SIDE;
  localparam int XP_NQ   = 4;
  localparam int XP_CW   = 2 * XP_SIDE + XP_NQ;
  localparam int XP_IW   = $clog2(XP_HALF);

  // Quadrant slot numbers inside the quadrant parity field
  localparam int QA = 0; // upper rows, left cols
  localparam int QB = 1; // upper rows, right cols
  localparam int QC = 2; // lower rows, right cols
  localparam int QD = 3; // lower rows, left cols

  localparam logic [XP_NQ-1:0] PAIR_AC = 4'b0101;
  localparam logic [XP_NQ-1:0] PAIR_BD = 4'b1010;

  function automatic int xp_quad(input int r, input int c);
    if (r < XP_HALF) return (c < XP_HALF) ? QA : QB;
    else             return (c < XP_HALF) ? QD : QC;
  endfunction

  function automatic logic [XP_CW-1:0] xp_encode(input logic [XP_DW-1:0] d);
    logic [XP_CW-1:0] k;
    k = '0;
    for (int r = 0; r < XP_SIDE; r++) begin
      for (int c = 0; c < XP_SIDE; c++) begin
        k[r]                        ^= d[r*XP_SIDE + c];
        k[XP_SIDE + c]              ^= d[r*XP_SIDE + c];
        k[2*XP_SIDE + xp_quad(r, c)] ^= d[r*XP_SIDE + c];
      end
    end
    return k;
  endfunction

  function automatic logic [XP_IW-1:0] xp_pos(input logic [XP_HALF-1:0] v);
    logic [XP_IW-1:0] p;
    p = '0;
    for (int i = 0; i < XP_HALF; i++)
      if (v[i]) p = XP_IW'(i);
    return p;
  endfunction
endpackage

// File: rtl/xp_encoder.sv
module xp_encoder
  import xp_ecc_pkg::*;
(
  input  logic [XP_DW-1:0] data_i,
  output logic [XP_CW-1:0] check_o
);
  assign check_o = xp_encode(data_i);
endmodule

// File: rtl/xp_syndrome.sv
module xp_syndrome
  import xp_ecc_pkg::*;
(
  input  logic [XP_DW-1:0]   data_i,
  input  logic [XP_CW-1:0]   check_i,
  output logic [XP_SIDE-1:0] syn_row_o,
  output logic [XP_SIDE-1:0] syn_col_o,
  output logic [XP_NQ-1:0]   syn_quad_o
);
  logic [XP_CW-1:0] fresh;
  logic [XP_CW-1:0] diff;

  xp_encoder u_enc (.data_i(data_i), .check_o(fresh));

  assign diff       = fresh ^ check_i;
  assign syn_row_o  = diff[XP_SIDE-1:0];
  assign syn_col_o  = diff[2*XP_SIDE-1:XP_SIDE];
  assign syn_quad_o = diff[XP_CW-1:2*XP_SIDE];
endmodule

// File: rtl/xp_locator.sv
module xp_locator
  import xp_ecc_pkg::*;
(
  input  logic [XP_SIDE-1:0] syn_row_i,
  input  logic [XP_SIDE-1:0] syn_col_i,
  input  logic [XP_NQ-1:0]   syn_quad_i,
  output logic [XP_DW-1:0]   flip_o,
  output logic               fix_o,
  output logic               bad_o,
  output logic               clean_o
);
  logic [XP_HALF-1:0] row_up, row_lo, col_lf, col_rt;
  logic               one_row, one_col, split_ok;
  logic               single_hit, double_hit;
  int                 rs, cs, ru, rl, cl, cr;
  logic [XP_NQ-1:0]   want_q;

  assign row_up = syn_row_i[XP_HALF-1:0];
  assign row_lo = syn_row_i[XP_SIDE-1:XP_HALF];
  assign col_lf = syn_col_i[XP_HALF-1:0];
  assign col_rt = syn_col_i[XP_SIDE-1:XP_HALF];

  assign clean_o  = (syn_row_i == '0) && (syn_col_i == '0) && (syn_quad_i == '0);
  assign one_row  = ($countones(syn_row_i) == 1);
  assign one_col  = ($countones(syn_col_i) == 1);
  assign split_ok = ($countones(row_up) == 1) && ($countones(row_lo) == 1) &&
                    ($countones(col_lf) == 1) && ($countones(col_rt) == 1);

  always_comb begin
    rs = 0;
    cs = 0;
    for (int i = 0; i < XP_SIDE; i++) begin
      if (syn_row_i[i]) rs = i;
      if (syn_col_i[i]) cs = i;
    end
    ru = int'(xp_pos(row_up));
    rl = XP_HALF + int'(xp_pos(row_lo));
    cl = int'(xp_pos(col_lf));
    cr = XP_HALF + int'(xp_pos(col_rt));
    want_q = '0;
    want_q[xp_quad(rs, cs)] = 1'b1;

    single_hit = one_row && one_col && (syn_quad_i == want_q);
    double_hit = split_ok && ((syn_quad_i == PAIR_AC) || (syn_quad_i == PAIR_BD));

    flip_o = '0;
    if (single_hit) begin
      flip_o[rs*XP_SIDE + cs] = 1'b1;
    end else if (double_hit) begin
      if (syn_quad_i == PAIR_AC) begin
        flip_o[ru*XP_SIDE + cl] = 1'b1;
        flip_o[rl*XP_SIDE + cr] = 1'b1;
      end else begin
        flip_o[ru*XP_SIDE + cr] = 1'b1;
        flip_o[rl*XP_SIDE + cl] = 1'b1;
      end
    end
  end

  assign fix_o = single_hit || double_hit;
  assign bad_o = !clean_o && !fix_o;

  // A repair never touches more than two data bits, and only a fix touches any
  always_comb begin
    AST_FLIP_WEIGHT: assert (fix_o ? ($countones(flip_o) inside {1, 2}) : (flip_o == '0)); // R5
  end
endmodule

// File: rtl/xp_ecc_codec.sv
module xp_ecc_codec
  import xp_ecc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [63:0]      enc_data_i,
  output logic [19:0]      enc_check_o,
  input  logic             dec_valid_i,
  input  logic [63:0]      dec_data_i,
  input  logic [19:0]      dec_check_i,
  output logic [63:0]      corrected_data,
  output logic [19:0]      check_out,
  output logic             err_corrected,
  output logic             err_uncorrectable
);
  logic [XP_SIDE-1:0] syn_row;
  logic [XP_SIDE-1:0] syn_col;
  logic [XP_NQ-1:0]   syn_quad;
  logic [XP_DW-1:0]   flip_w;
  logic               fix_w, bad_w, clean_w;
  logic [XP_DW-1:0]   fixed_w;
  logic [XP_CW-1:0]   regen_w;

  xp_encoder u_enc_port (.data_i(enc_data_i), .check_o(enc_check_o));

  xp_syndrome u_syn (
    .data_i    (dec_data_i),
    .check_i   (dec_check_i),
    .syn_row_o (syn_row),
    .syn_col_o (syn_col),
    .syn_quad_o(syn_quad)
  );

  xp_locator u_loc (
    .syn_row_i (syn_row),
    .syn_col_i (syn_col),
    .syn_quad_i(syn_quad),
    .flip_o    (flip_w),
    .fix_o     (fix_w),
    .bad_o     (bad_w),
    .clean_o   (clean_w)
  );

  assign fixed_w = dec_data_i ^ flip_w;

  xp_encoder u_enc_regen (.data_i(fixed_w), .check_o(regen_w));

  always_ff @(posedge clk) begin
    if (rst) begin
      corrected_data    <= '0;
      check_out         <= '0;
      err_corrected     <= 1'b0;
      err_uncorrectable <= 1'b0;
    end else if (dec_valid_i) begin
      corrected_data    <= fixed_w;
      check_out         <= regen_w;
      err_corrected     <= fix_w;
      err_uncorrectable <= bad_w;
    end else begin
      err_corrected     <= 1'b0;
      err_uncorrectable <= 1'b0;
    end
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(err_corrected && err_uncorrectable)); // R11

  AST_IDLE_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
    !dec_valid_i |=> (!err_corrected && !err_uncorrectable)); // R2

  AST_IDLE_HOLDS_DATA: assert property (@(posedge clk) disable iff (rst)
    !dec_valid_i |=> ($stable(corrected_data) && $stable(check_out))); // R2

  AST_BAD_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    (dec_valid_i && bad_w) |=> (corrected_data == $past(dec_data_i))); // R5

  AST_FIX_DISTANCE: assert property (@(posedge clk) disable iff (rst)
    dec_valid_i |=> (!err_corrected ||
      ($countones(corrected_data ^ $past(dec_data_i)) inside {1, 2}))); // R3

  AST_CLEAN_PASSES: assert property (@(posedge clk) disable iff (rst)
    (dec_valid_i && clean_w) |=> (!err_corrected && !err_uncorrectable &&
      corrected_data == $past(dec_data_i))); // R9

  AST_REGEN_MATCHES: assert property (@(posedge clk) disable iff (rst)
    check_out == xp_encode(corrected_data)); // R8
endmodule

// File: tb/xp_ecc_codec_test.sv
`timescale 1ns/1ps
module xp_ecc_codec_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] enc_data_i = '0;
  logic [19:0] enc_check_o;
  logic        dec_valid_i = 1'b0;
  logic [63:0] dec_data_i = '0;
  logic [19:0] dec_check_i = '0;
  logic [63:0] corrected_data;
  logic [19:0] check_out;
  logic        err_corrected, err_uncorrectable;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk; // 250 MHz

  xp_ecc_codec uut (
    .clk(clk), .rst(rst),
    .enc_data_i(enc_data_i), .enc_check_o(enc_check_o),
    .dec_valid_i(dec_valid_i), .dec_data_i(dec_data_i), .dec_check_i(dec_check_i),
    .corrected_data(corrected_data), .check_out(check_out),
    .err_corrected(err_corrected), .err_uncorrectable(err_uncorrectable)
  );

  // Independent parity model: walk bit index, derive row/col by division
  function automatic logic [19:0] ref_par(input logic [63:0] d);
    logic [19:0] k;
    k = '0;
    for (int i = 0; i < 64; i++) begin
      int r, c, q;
      r = i / 8;
      c = i % 8;
      if (r < 4) q = (c < 4) ? 0 : 1;
      else       q = (c < 4) ? 3 : 2;
      if (d[i]) begin
        k[r]      = ~k[r];
        k[8 + c]  = ~k[8 + c];
        k[16 + q] = ~k[16 + q];
      end
    end
    return k;
  endfunction

  function automatic string tag(input logic [3:0] n);
    case (n)
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // {data error mask, check error mask, expect {corrected,uncorrectable}, requirement}
  localparam int NV = 18;
  localparam logic [89:0] VEC [NV] = '{
    {64'h0000_0000_0000_0000, 20'h00000, 2'b00, 4'd9}, // clean word
    {64'h0000_0000_0000_0001, 20'h00000, 2'b10, 4'd3}, // bit 0
    {64'h8000_0000_0000_0000, 20'h00000, 2'b10, 4'd3}, // bit 63
    {64'h0000_0000_0800_0000, 20'h00000, 2'b10, 4'd3}, // bit 27 (3,3)
    {64'h0020_0000_0000_0400, 20'h00000, 2'b10, 4'd4}, // (1,2)+(6,5) QA/QC
    {64'h0100_0000_0000_0080, 20'h00000, 2'b10, 4'd4}, // (0,7)+(7,0) QB/QD
    {64'h0000_0000_0000_0003, 20'h00000, 2'b01, 4'd5}, // same row
    {64'h0000_0000_0000_0201, 20'h00000, 2'b01, 4'd5}, // same quadrant
    {64'h0000_0000_0000_2001, 20'h00000, 2'b01, 4'd5}, // QA+QB
    {64'h0000_0200_0000_0001, 20'h00000, 2'b01, 4'd5}, // QA+QD
    {64'h0000_0000_0000_0000, 20'h00001, 2'b01, 4'd6}, // one row check bit
    {64'h0000_0000_0000_0000, 20'h00101, 2'b01, 4'd6}, // row0 + col0 check bits
    {64'h0000_0000_0000_00E0, 20'h00000, 2'b01, 4'd7}, // burst 3 at bit 5
    {64'h0000_0007_F000_0000, 20'h00000, 2'b01, 4'd7}, // burst 7 at bit 28
    {64'h0000_0001_8000_0000, 20'h00000, 2'b10, 4'd7}, // burst 2 at 31/32
    {64'hF000_0000_0000_0000, 20'h00000, 2'b01, 4'd7}, // burst 4 at bit 60
    {64'h0000_0000_0000_0000, 20'h80000, 2'b01, 4'd6}, // one quadrant check bit
    {64'h8000_0000_0000_0001, 20'h00000, 2'b10, 4'd4}  // corners QA/QC
  };

  task automatic apply(input logic [63:0] d, input logic [19:0] k);
    @(negedge clk);
    dec_data_i  = d;
    dec_check_i = k;
    dec_valid_i = 1'b1;
    @(negedge clk);
    dec_valid_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] base, emask, rx, exp_d;
    logic [19:0] kmask;
    logic [1:0]  fl;
    string       rq;

    // R10: reset holds outputs at zero even while strobed
    dec_valid_i = 1'b1;
    dec_data_i  = 64'hFFFF_0000_1234_5678;
    dec_check_i = 20'h0;
    repeat (3) @(negedge clk);
    chk("R10", "reset data", corrected_data, '0);
    chk("R10", "reset check", {44'h0, check_out}, '0);
    chk("R10", "reset flags", {62'h0, err_corrected, err_uncorrectable}, '0);
    dec_valid_i = 1'b0;
    rst = 1'b0;

    // R1: encoder port
    enc_data_i = 64'h0000_0010_0000_0000; // bit 36 = (4,4): row4, col4, QC
    #1 chk("R1", "enc bit36", {44'h0, enc_check_o}, {44'h0, 20'h41010});
    enc_data_i = 64'hFFFF_FFFF_FFFF_FFFF; // every row/col/quad has even count
    #1 chk("R1", "enc ones", {44'h0, enc_check_o}, '0);
    enc_data_i = 64'h0123_4567_89AB_CDEF;
    #1 chk("R1", "enc mix", {44'h0, enc_check_o}, {44'h0, ref_par(64'h0123_4567_89AB_CDEF)});

    // Table walk
    for (int v = 0; v < NV; v++) begin
      base  = {32'(v) * 32'h9E37_79B9, 32'hC0FF_EE00 ^ 32'(v * 7)};
      emask = VEC[v][89:26];
      kmask = VEC[v][25:6];
      fl    = VEC[v][5:4];
      rq    = tag(VEC[v][3:0]);
      rx    = base ^ emask;
      exp_d = fl[0] ? rx : base;
      apply(rx, ref_par(base) ^ kmask);
      chk(rq, "data", corrected_data, exp_d);
      chk("R8", "regen check", {44'h0, check_out}, {44'h0, ref_par(exp_d)});
      chk(rq, "corrected flag", {63'h0, err_corrected}, {63'h0, fl[1]});
      chk(rq, "uncorrectable flag", {63'h0, err_uncorrectable}, {63'h0, fl[0]});
      chk("R11", "flags exclusive", {63'h0, err_corrected & err_uncorrectable}, '0);
    end

    // R2: idle cycle after a fix clears flags and holds data
    base = 64'hDEAD_BEEF_0BAD_F00D;
    apply(base ^ 64'h1, ref_par(base));
    chk("R3", "fix before idle", corrected_data, base);
    @(negedge clk);
    chk("R2", "idle data hold", corrected_data, base);
    chk("R2", "idle check hold", {44'h0, check_out}, {44'h0, ref_par(base)});
    chk("R2", "idle flags", {62'h0, err_corrected, err_uncorrectable}, '0);

    // R2: strobe low while inputs change has no effect
    dec_data_i  = 64'h1111_2222_3333_4444;
    dec_check_i = 20'hFFFFF;
    @(negedge clk);
    chk("R2", "ignored input", corrected_data, base);

    // R10: mid-run reset
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10", "mid reset data", corrected_data, '0);
    chk("R10", "mid reset check", {44'h0, check_out}, '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule